// File: doc/BRIEF.md
# Parallel Bus Read Sequencer with Wait Stretching

This block is the read side of a processor bus master. A requester presents an address together with a one-cycle request, and the block then runs one read cycle on a parallel bus. In the first phase the address goes out with its output enable set. In the second phase the active-low read strobe falls. In the last phase the block samples the data bus. The captured byte comes back on a one-cycle completion pulse.

Slow targets can lengthen the cycle in two ways, and both add cycles between the strobe phase and the capture phase. The first is a fixed number of wait states chosen by the top address bit. The lower half of the address space is the slow non-volatile region and the upper half is the working-memory region, and each half has its own parameter (0 to 7). The second is a target-driven hold input. The block samples it only after the fixed wait states have run out, and the cycle continues for as long as it stays high. The block takes a new request only while it is idle.

Top module: `bus_read_seq`

## Requirements
- R1: While reset is active, and after it is released, busy is 0, rdN is 1, busAddrOe is 0 and doneValid is 0.
- R2: In the cycle after a request is accepted (first phase), busy is 1, busAddrOe is 1, busAddr equals the request address, and rdN is still 1.
- R3: rdN is low for one unbroken run that starts in the second phase and ends with the capture phase. The run is 2 + W + H cycles long, where W is the region's wait count and H is the number of hold cycles.
- R4: Address bit 15 selects the region. When it is 0, W is ROM_WAITS (default 2). When it is 1, W is RAM_WAITS (default 1).
- R5: waitIn is ignored during the strobe phase and during the programmed wait states. A high level there adds no cycles.
- R6: Once the programmed waits are used up, each rising edge that finds waitIn high adds one cycle. The capture phase starts on the first edge that finds waitIn low.
- R7: busAddr stays stable and busAddrOe stays high from the first phase through the capture phase.
- R8: busData is captured on the edge that ends the capture phase, which is the last cycle with rdN low. doneValid is high for exactly one cycle, the cycle right after that edge, and doneData holds the captured value during it.
- R9: A request raised while busy is 1 is ignored. The bus address does not change, and no new cycle starts when the current one ends.
- R10: busy is high from the first phase through the capture phase and low in the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Read request; taken only when idle |
| reqAddr | input | ADDR_W | Address of the requested read |
| waitIn | input | 1 | Hold request from the target, active high |
| busData | input | DATA_W | Data bus driven by the target |
| busAddr | output | ADDR_W | Address driven on the bus |
| busAddrOe | output | 1 | Output enable for the address pads |
| rdN | output | 1 | Read strobe, active low |
| busy | output | 1 | Cycle in progress |
| doneValid | output | 1 | One-cycle completion pulse |
| doneData | output | DATA_W | Captured read data |

## Verification
The bench counts the strobe-low cycles for addresses on both sides of the region split, including 0x7FFF and 0x8000. A design that decoded the wrong bit, or swapped the two wait counts, would give strobe runs of the wrong length.

The bench holds waitIn high for the whole programmed wait period. A design that sampled waitIn too early would stretch the cycle even though no extra hold was requested.

The bench drives inverted data on the bus except in the final strobe cycle. A design that captured data one cycle early or one cycle late would return the inverted byte.

A request is also raised in the middle of a cycle. A design that accepted it would move the address or start a second cycle after the completion pulse.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_STROBE,
    PH_WAITST,
    PH_HOLD,
    PH_CAPTURE
  } phase_e;

  typedef struct packed {
    logic loadAddr;
    logic loadCnt;
    logic decCnt;
    logic capture;
  } strobe_t;
endpackage

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    waitIn,
  input  logic    cntZero,
  input  logic    cntOne,
  output strobe_t strobes,
  output logic    busy,
  output logic    rdN
);
  phase_e phase, phaseNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strobes   = '0;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          strobes.loadAddr = 1'b1;
          phaseNext        = PH_ADDR;
        end
      end
      PH_ADDR: begin
        strobes.loadCnt = 1'b1;
        phaseNext       = PH_STROBE;
      end
      PH_STROBE: begin
        if (!cntZero)    phaseNext = PH_WAITST;
        else if (waitIn) phaseNext = PH_HOLD;
        else             phaseNext = PH_CAPTURE;
      end
      PH_WAITST: begin
        strobes.decCnt = 1'b1;
        if (cntOne) phaseNext = waitIn ? PH_HOLD : PH_CAPTURE;
      end
      PH_HOLD: begin
        if (!waitIn) phaseNext = PH_CAPTURE;
      end
      PH_CAPTURE: begin
        strobes.capture = 1'b1;
        phaseNext       = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  assign busy = (phase != PH_IDLE);
  assign rdN  = (phase == PH_IDLE) || (phase == PH_ADDR);
endmodule

// File: rtl/brs_dpath.sv
module brs_dpath
  import brs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int MAX_WAITS = 7,
  parameter int ROM_WAITS = 2,
  parameter int RAM_WAITS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] busData,
  output logic [ADDR_W-1:0] addrReg,
  output logic              cntZero,
  output logic              cntOne,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneData
);
  localparam int CNT_W = $clog2(MAX_WAITS + 1);
  localparam int REGIONS = 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] regionWaits [REGIONS];
  logic [CNT_W-1:0] waitCnt;
  logic             regionSel;

  for (genvar r = 0; r < REGIONS; r++) begin : g_region
    localparam int W = (r == 0) ? ROM_WAITS : RAM_WAITS;
    assign regionWaits[r] = CNT_W'((W > MAX_WAITS) ? MAX_WAITS : W);
  end

  assign regionSel = addrReg[ADDR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrReg   <= '0;
      waitCnt   <= '0;
      doneValid <= 1'b0;
      doneData  <= '0;
    end else begin
      if (strobes.loadAddr) addrReg <= reqAddr;
      if (strobes.loadCnt)     waitCnt <= regionWaits[regionSel];
      else if (strobes.decCnt) waitCnt <= waitCnt - ONE;
      doneValid <= strobes.capture;
      if (strobes.capture) doneData <= busData;
    end
  end

  assign cntZero = (waitCnt == '0);
  assign cntOne  = (waitCnt == ONE);
endmodule

// File: rtl/bus_read_seq.sv
module bus_read_seq
  import brs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int MAX_WAITS = 7,
  parameter int ROM_WAITS = 2,
  parameter int RAM_WAITS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              waitIn,
  input  logic [DATA_W-1:0] busData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busAddrOe,
  output logic              rdN,
  output logic              busy,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneData
);
  strobe_t strobes;
  logic    cntZero, cntOne;

  brs_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .waitIn   (waitIn),
    .cntZero  (cntZero),
    .cntOne   (cntOne),
    .strobes  (strobes),
    .busy     (busy),
    .rdN      (rdN)
  );

  brs_dpath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAX_WAITS (MAX_WAITS),
    .ROM_WAITS (ROM_WAITS),
    .RAM_WAITS (RAM_WAITS)
  ) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .reqAddr   (reqAddr),
    .busData   (busData),
    .addrReg   (busAddr),
    .cntZero   (cntZero),
    .cntOne    (cntOne),
    .doneValid (doneValid),
    .doneData  (doneData)
  );

  assign busAddrOe = busy;
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              rdN,
  input logic              busy,
  input logic              doneValid
);
  // R3: a low strobe only occurs inside a busy cycle
  assert_strobe_in_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rdN |-> busy);

  // R2: the first busy cycle still has the strobe high
  assert_addr_phase_strobe_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rdN);

  // R7: the address holds while the cycle continues
  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(busAddr));

  // R8: the completion pulse lasts one cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid);

  // R8: completion follows directly after the last strobe-low cycle
  assert_done_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> (rdN && $past(!rdN)));

  // R10: busy is low during the completion cycle
  assert_idle_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> !busy);
endmodule

bind bus_read_seq brs_checker #(.ADDR_W(ADDR_W)) checker_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busAddr   (busAddr),
  .rdN       (rdN),
  .busy      (busy),
  .doneValid (doneValid)
);

// File: tb/bus_read_seq_tb_top.sv
module bus_read_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int ROM_WAITS  = 2;
  localparam int RAM_WAITS  = 1;
  localparam int NVEC       = 7;
  // {address, hold cycles}
  localparam logic [23:0] VECS [NVEC] = '{
    {16'h1234, 8'd0}, {16'h9ABC, 8'd0}, {16'h0FF0, 8'd3}, {16'hFFFF, 8'd1},
    {16'h7FFF, 8'd0}, {16'h8000, 8'd5}, {16'h0000, 8'd2}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              waitIn = 1'b0;
  logic [DATA_W-1:0] busData = '0;
  logic [ADDR_W-1:0] busAddr;
  logic              busAddrOe, rdN, busy, doneValid;
  logic [DATA_W-1:0] doneData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_read_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_WAITS(ROM_WAITS), .RAM_WAITS(RAM_WAITS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .waitIn(waitIn), .busData(busData), .busAddr(busAddr), .busAddrOe(busAddrOe),
    .rdN(rdN), .busy(busy), .doneValid(doneValid), .doneData(doneData)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] dataOf(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic runRead(input logic [ADDR_W-1:0] a, input int hold, input bit poke);
    int n, lowCnt, cyc;
    bit seenDone, addrOk;
    logic [DATA_W-1:0] expD;
    n = a[15] ? RAM_WAITS : ROM_WAITS;   // R4 region selection
    expD = dataOf(a);
    @(negedge clk); reqValid = 1'b1; reqAddr = a;
    @(negedge clk); reqValid = 1'b0; reqAddr = '0;
    chk(busy && busAddrOe && rdN && busAddr == a, "R2 address phase",
        {busy, busAddrOe, rdN, 13'd0, busAddr}, {3'b111, 13'd0, a});
    lowCnt = 0; cyc = 0; seenDone = 0; addrOk = 1;
    while (!seenDone && cyc < 64) begin
      reqValid = 1'b0;
      if (!rdN) begin
        // R5/R6: high through programmed waits, then for 'hold' sampled edges
        waitIn  = (lowCnt < n + hold);
        busData = (lowCnt == n + hold + 1) ? expD : ~expD;
        if (poke && lowCnt == 0) begin reqValid = 1'b1; reqAddr = ~a; end
        lowCnt++;
      end else begin
        waitIn = 1'b0;
      end
      if (!(busy && busAddrOe && busAddr == a)) addrOk = 0;
      @(negedge clk); cyc++;
      if (doneValid) seenDone = 1;
    end
    waitIn = 1'b0;
    chk(addrOk, "R7 address held with enable", 32'(addrOk), 32'd1);
    chk(lowCnt == 2 + n + hold, "R3/R4/R5/R6 strobe length", 32'(lowCnt), 32'(2 + n + hold));
    chk(cyc == n + hold + 3, "R8 completion timing", 32'(cyc), 32'(n + hold + 3));
    chk(doneData == expD, "R8 captured data", 32'(doneData), 32'(expD));
    chk(rdN && !busy, "R10 idle in completion cycle", {30'd0, rdN, busy}, 32'd2);
    @(negedge clk);
    chk(!doneValid, "R8 single pulse", 32'(doneValid), 32'd0);
    chk(!busy && rdN, "R9 no extra cycle started", {30'd0, busy, rdN}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && rdN && !busAddrOe && !doneValid, "R1 in reset",
        {28'd0, busy, rdN, busAddrOe, doneValid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && rdN && !busAddrOe && !doneValid, "R1 after reset",
        {28'd0, busy, rdN, busAddrOe, doneValid}, 32'd4);
    for (int i = 0; i < NVEC; i++) begin
      runRead(VECS[i][23:8], int'(VECS[i][7:0]), 1'b0);
    end
    // R9: request raised while busy must be ignored
    runRead(16'h4321, 1, 1'b1);
    runRead(16'hC0DE, 2, 1'b1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule